// File: doc/BRIEF.md
# Link Slumber Power-State Handler

This block manages the low-power slumber state of a serial storage link. The attached device may ask to enter slumber. The block answers each such request with an acknowledge pulse or a negative-acknowledge pulse, chosen by a host-controlled enable bit. It tracks whether the link is currently in slumber and shows that condition in two status views: a 4-bit interface power field and one bit of a miscellaneous status word.

The link can leave slumber in two ways. In the first, the host writes the wake bit, and the block emits a one-cycle request asking the physical layer to send a wake signal. In the second, the device starts out-of-band signalling, and the block returns to the active state without emitting anything. The physical-layer signalling itself is handled outside this block. All outputs are registered or derived directly from registered state, so every response appears one clock after the stimulus that caused it.

Top module: `slp_handler`

## Requirements
- R1: After reset the block is active: `ipm_o` is 4'b0001, `misc_o` is all zero, and `ack_o`, `nak_o`, `wake_o` and `wake_bit_o` are 0.
- R2: A `slp_req_i` pulse while active with `ack_en_i`=1 gives `ack_o`=1 in the next cycle, and the block is in slumber from that same cycle.
- R3: A `slp_req_i` pulse while active with `ack_en_i`=0 gives `nak_o`=1 in the next cycle, and the block stays active.
- R4: While in slumber, `ipm_o` reads 4'b0110. While active, it reads 4'b0001.
- R5: While in slumber, bit 5 of `misc_o` reads 1 and every other bit of `misc_o` reads 0. While active, all bits of `misc_o` read 0.
- R6: A `wake_wr_i` strobe while in slumber gives `wake_o`=1 in the next cycle, and the block is active from that same cycle.
- R7: `wake_bit_o` reads 1 only in the cycle of the `wake_o` pulse and reads 0 one cycle later, because the bit clears itself.
- R8: An `oob_det_i` pulse while in slumber, with no wake strobe in the same cycle, makes the block active in the next cycle with no `wake_o` pulse.
- R9: A `slp_req_i` pulse while in slumber produces neither `ack_o` nor `nak_o`.
- R10: `ack_o`, `nak_o` and `wake_o` are single-cycle pulses, and at most one of them is high in any cycle.
- R11: While active, `wake_wr_i` and `oob_det_i` are ignored: they cause no `wake_o` pulse, `wake_bit_o` stays 0, and the status stays active.
- R12: When a wake strobe and an OOB pulse arrive in the same slumber cycle, the wake strobe wins and `wake_o` is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slp_req_i | input | 1 | Slumber request pulse from the device |
| ack_en_i | input | 1 | Host enable for acknowledging slumber requests |
| wake_wr_i | input | 1 | Host strobe that writes 1 to the wake bit |
| oob_det_i | input | 1 | Pulse indicating out-of-band signalling detected from the device |
| ack_o | output | 1 | Acknowledge pulse |
| nak_o | output | 1 | Negative-acknowledge pulse |
| wake_o | output | 1 | Request pulse to send a wake signal |
| wake_bit_o | output | 1 | Read-back value of the self-clearing wake bit |
| ipm_o | output | IPM_W (4) | Interface power field |
| misc_o | output | MISC_W (8) | Miscellaneous status word; bit 5 shows slumber |

## Verification
The only internal state is the slumber flag plus the three pulse registers. A wrong value in any of them therefore shows up at the ports in the very next cycle:
- A flag stuck in slumber shows as `ipm_o` reading 0110 and misc bit 5 set where 0001 and 0 were expected.
- A lost or extra pulse shows as a missing or doubled `ack_o`, `nak_o` or `wake_o`.

The bench starts from both states and applies every combination of the four inputs. It compares the cycle right after the stimulus and the cycle after that against a two-state arithmetic model, so each fault is caught within two clocks.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic {
        PWR_ACTIVE  = 1'b0,
        PWR_SLUMBER = 1'b1
    } pwr_e;

    typedef struct packed {
        pwr_e pwr;
        logic ack;
        logic nak;
        logic wake;
    } slp_state_t;

    localparam slp_state_t SLP_RESET = '{pwr: PWR_ACTIVE, ack: 1'b0, nak: 1'b0, wake: 1'b0};

endpackage

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic ack_en_i,
    input  logic wake_wr_i,
    input  logic oob_i,
    output pwr_e pwr_o,
    output logic ack_o,
    output logic nak_o,
    output logic wake_o
);

    slp_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ack  = 1'b0;
        st_d.nak  = 1'b0;
        st_d.wake = 1'b0;
        unique case (st_q.pwr)
            PWR_ACTIVE: begin
                // wake strobe and device OOB have no meaning while active
                if (req_i) begin
                    if (ack_en_i) begin
                        st_d.ack = 1'b1;
                        st_d.pwr = PWR_SLUMBER;
                    end else begin
                        st_d.nak = 1'b1;
                    end
                end
            end
            PWR_SLUMBER: begin
                // requests are ignored here; host wake takes priority over OOB
                if (wake_wr_i) begin
                    st_d.wake = 1'b1;
                    st_d.pwr  = PWR_ACTIVE;
                end else if (oob_i) begin
                    st_d.pwr  = PWR_ACTIVE;
                end
            end
            default: st_d = SLP_RESET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= SLP_RESET;
        else         st_q <= st_d;
    end

    assign pwr_o  = st_q.pwr;
    assign ack_o  = st_q.ack;
    assign nak_o  = st_q.nak;
    assign wake_o = st_q.wake;

endmodule

// File: rtl/slp_status.sv
module slp_status
    import slp_pkg::*;
#(
    parameter int              IPM_W          = 4,
    parameter logic [IPM_W-1:0] IPM_ACTIVE    = 4'b0001,
    parameter logic [IPM_W-1:0] IPM_SLUMBER   = 4'b0110,
    parameter int              MISC_W         = 8,
    parameter int              MISC_SLP_BIT   = 5
) (
    input  pwr_e              pwr_i,
    output logic [IPM_W-1:0]  ipm_o,
    output logic [MISC_W-1:0] misc_o
);

    logic in_slumber;

    always_comb begin
        in_slumber = (pwr_i == PWR_SLUMBER);
        ipm_o      = in_slumber ? IPM_SLUMBER : IPM_ACTIVE;
    end

    for (genvar b = 0; b < MISC_W; b++) begin : g_misc
        if (b == MISC_SLP_BIT) begin : g_flag
            assign misc_o[b] = in_slumber;
        end else begin : g_zero
            assign misc_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/slp_handler.sv
module slp_handler
    import slp_pkg::*;
#(
    parameter int IPM_W        = 4,
    parameter int MISC_W       = 8,
    parameter int MISC_SLP_BIT = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              slp_req_i,
    input  logic              ack_en_i,
    input  logic              wake_wr_i,
    input  logic              oob_det_i,
    output logic              ack_o,
    output logic              nak_o,
    output logic              wake_o,
    output logic              wake_bit_o,
    output logic [IPM_W-1:0]  ipm_o,
    output logic [MISC_W-1:0] misc_o
);

    localparam logic [IPM_W-1:0] IPM_ACTIVE  = IPM_W'(4'b0001);
    localparam logic [IPM_W-1:0] IPM_SLUMBER = IPM_W'(4'b0110);

    pwr_e pwr;
    logic wake_pulse;

    slp_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (slp_req_i),
        .ack_en_i  (ack_en_i),
        .wake_wr_i (wake_wr_i),
        .oob_i     (oob_det_i),
        .pwr_o     (pwr),
        .ack_o     (ack_o),
        .nak_o     (nak_o),
        .wake_o    (wake_pulse)
    );

    slp_status #(
        .IPM_W        (IPM_W),
        .IPM_ACTIVE   (IPM_ACTIVE),
        .IPM_SLUMBER  (IPM_SLUMBER),
        .MISC_W       (MISC_W),
        .MISC_SLP_BIT (MISC_SLP_BIT)
    ) u_status (
        .pwr_i  (pwr),
        .ipm_o  (ipm_o),
        .misc_o (misc_o)
    );

    // the wake bit is set for exactly the pulse cycle, then clears itself
    assign wake_o     = wake_pulse;
    assign wake_bit_o = wake_pulse;

endmodule

// File: rtl/slp_handler_chk.sv
module slp_handler_chk #(
    parameter int IPM_W        = 4,
    parameter int MISC_W       = 8,
    parameter int MISC_SLP_BIT = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              slp_req_i,
    input logic              ack_en_i,
    input logic              wake_wr_i,
    input logic              oob_det_i,
    input logic              ack_o,
    input logic              nak_o,
    input logic              wake_o,
    input logic              wake_bit_o,
    input logic [IPM_W-1:0]  ipm_o,
    input logic [MISC_W-1:0] misc_o
);

    logic slp;
    assign slp = misc_o[MISC_SLP_BIT];

    p_ack_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slp_req_i && ack_en_i && !slp) |=> (ack_o && slp));

    p_nak_stay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slp_req_i && !ack_en_i && !slp) |=> (nak_o && !slp));

    p_ipm_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> (ipm_o == IPM_W'(4'b0110)));

    p_misc_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slp == (ipm_o == IPM_W'(4'b0110)));

    p_wake_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slp && wake_wr_i) |=> (wake_o && !slp));

    p_bit_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_bit_o);

    p_oob_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slp && oob_det_i && !wake_wr_i) |=> (!slp && !wake_o));

    p_no_reply_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slp |=> (!ack_o && !nak_o));

    p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ack_o, nak_o, wake_o}));

    p_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o || nak_o || wake_o) |=> !(ack_o || nak_o || wake_o));

    p_active_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !slp |=> !wake_o);

endmodule

bind slp_handler slp_handler_chk #(
    .IPM_W        (IPM_W),
    .MISC_W       (MISC_W),
    .MISC_SLP_BIT (MISC_SLP_BIT)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slp_req_i  (slp_req_i),
    .ack_en_i   (ack_en_i),
    .wake_wr_i  (wake_wr_i),
    .oob_det_i  (oob_det_i),
    .ack_o      (ack_o),
    .nak_o      (nak_o),
    .wake_o     (wake_o),
    .wake_bit_o (wake_bit_o),
    .ipm_o      (ipm_o),
    .misc_o     (misc_o)
);

// File: tb/sim_slp_handler.sv
module sim_slp_handler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, en = 1'b0, wk = 1'b0, oob = 1'b0;
    logic       ack, nak, wake, wbit;
    logic [3:0] ipm;
    logic [7:0] misc;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    slp_handler u0 (
        .clk_i(clk), .rst_ni(rst_n), .slp_req_i(req), .ack_en_i(en),
        .wake_wr_i(wk), .oob_det_i(oob), .ack_o(ack), .nak_o(nak),
        .wake_o(wake), .wake_bit_o(wbit), .ipm_o(ipm), .misc_o(misc)
    );

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req_tag, act, exp, $time);
        end
    endtask

    // outputs expected for a given slumber flag and pulse set
    task automatic chk_all(input string tag, input logic s, input logic a,
                           input logic n, input logic w);
        chk({tag, " R4 ipm"},  32'(ipm),  s ? 32'h6 : 32'h1);
        chk({tag, " R5 misc"}, 32'(misc), s ? 32'h20 : 32'h0);
        chk({tag, " R2 ack"},  32'(ack),  32'(a));
        chk({tag, " R3 nak"},  32'(nak),  32'(n));
        chk({tag, " R6 wake"}, 32'(wake), 32'(w));
        chk({tag, " R7 wbit"}, 32'(wbit), 32'(w));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = 0; en = 0; wk = 0; oob = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic one_cycle(input logic r, input logic e, input logic w, input logic o);
        req = r; en = e; wk = w; oob = o;
        @(negedge clk);
        req = 0; wk = 0; oob = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk_all("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);

        for (int start = 0; start < 2; start++) begin
            for (int c = 0; c < 16; c++) begin
                logic r, e, w, o, s, xs, xa, xn, xw;
                r = c[0]; e = c[1]; w = c[2]; o = c[3];
                do_reset();
                s = 1'b0;
                if (start == 1) begin
                    one_cycle(1'b1, 1'b1, 1'b0, 1'b0);
                    chk_all("R2 enter", 1'b1, 1'b1, 1'b0, 1'b0);
                    s = 1'b1;
                end
                @(negedge clk);
                // model: active answers requests; slumber ignores them (R9),
                // wake beats OOB (R12), active ignores wake and OOB (R11)
                xs = s; xa = 0; xn = 0; xw = 0;
                if (!s) begin
                    if (r) begin
                        if (e) begin xa = 1; xs = 1; end
                        else   xn = 1;
                    end
                end else begin
                    if (w)      begin xw = 1; xs = 0; end
                    else if (o) xs = 0;
                end
                one_cycle(r, e, w, o);
                chk_all(s ? (w ? (o ? "R12 wake+oob" : "R6 wake") : (o ? "R8 oob" : "R9 slumber"))
                          : (r ? (e ? "R2 req" : "R3 req") : "R11 active"),
                        xs, xa, xn, xw);
                @(negedge clk);
                chk_all("R10 R7 after", xs, 1'b0, 1'b0, 1'b0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule